// File: doc/BRIEF.md
# Packed SIMD Integer Arithmetic Unit

This execution unit treats two 64-bit source operands as packed vectors and performs one arithmetic operation independently in every lane. The lane width is 8, 16 or 32 bits. It is chosen by a one-hot three-bit field of the instruction word. A two-bit operation select chooses lane-wise add, subtract, unsigned multiply or signed multiply. Add and subtract wrap inside each lane, and no carry or borrow crosses into the next lane. Each multiply keeps the low lane-width bits of every lane product, so the packed result stays 64 bits wide.

A small decoder inside the unit checks the bits that mark the vector form of the instruction. It also turns the width field into an internal lane-width state: one of 8-bit, 16-bit, 32-bit, or none for an unusable code. If the instruction is not in vector form, or the width code is not one of the three legal codes, the unit raises an illegal flag and returns a zero result. The result is registered: a request presented with `in_valid` in one cycle appears at the outputs after the next rising clock edge. While no request is presented, the last result is held.

Top module: `simd_alu_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first request, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: A request sampled with `in_valid` high at a rising edge sets `out_valid` high with its result from that edge on. In a cycle without a request, `out_valid` goes low and `out_result` keeps its previous value.
- R3: An instruction is in vector form only when `instr[31:30]` = 2'b10, `instr[13]` = 0 and `instr[6:5]` = 2'b10. Any other combination gives `out_illegal` = 1 and `out_result` = 0.
- R4: `instr[9:7]` selects the lane width: 3'b001 gives eight 8-bit lanes, 3'b010 gives four 16-bit lanes, and 3'b100 gives two 32-bit lanes. Every other code gives `out_illegal` = 1 and `out_result` = 0.
- R5: `op_sel` encodes the operation: 2'b00 add, 2'b01 subtract, 2'b10 unsigned multiply, 2'b11 signed multiply.
- R6: Add produces, in every lane, (a + b) mod 2^lane-width. The carry out of a lane never reaches the next lane.
- R7: Subtract produces, in every lane, (a - b) mod 2^lane-width. A borrow never crosses a lane boundary.
- R8: Unsigned multiply produces, in every lane, the low lane-width bits of the unsigned product of the two lane values.
- R9: Signed multiply produces, in every lane, the low lane-width bits of the two's-complement product of the two lane values.
- R10: The fields `instr[29:14]`, `instr[12:10]` and `instr[4:0]` have no effect on `out_result` or `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A request is presented in this cycle |
| instr | input | 32 | Instruction word holding the form bits and the lane-width code |
| op_sel | input | 2 | Operation select (R5 encoding) |
| opa | input | 64 | First packed source operand |
| opb | input | 64 | Second packed source operand |
| out_valid | output | 1 | A result was registered at the last edge |
| out_result | output | 64 | Packed lane-wise result |
| out_illegal | output | 1 | The last request had a bad form or a bad width code |

## Verification
A wrong lane-width state shows at the ports one cycle after the request. A misplaced carry cut corrupts the lowest bit of the next lane when the lane below overflows, which an all-ones plus one pattern brings out at once. A decoder that accepts a bad code leaves a non-zero `out_result` with `out_illegal` low in the very next output cycle. A wrong hold or valid register shows up in the first idle cycle after a request. Boundary operands (zero, all-ones, the most negative lane value) are mixed with random operands at every width, and every lane is compared against a lane-by-lane model.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_UMUL = 2'b10,
        OP_SMUL = 2'b11
    } simd_op_e;

    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_NONE = 2'd3
    } lane_w_e;

    localparam logic [2:0] CODE_W8  = 3'b001;
    localparam logic [2:0] CODE_W16 = 3'b010;
    localparam logic [2:0] CODE_W32 = 3'b100;

    localparam logic [1:0] FORM_TOP = 2'b10;
    localparam logic [1:0] FORM_LOW = 2'b10;

    // number of base segments that make up one lane of the given width
    function automatic int segs_per_lane(input lane_w_e w);
        int n;
        unique case (w)
            LW_8:    n = 1;
            LW_16:   n = 2;
            LW_32:   n = 4;
            default: n = 1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/simd_decode.sv
`timescale 1ns/1ps
module simd_decode
    import simd_pkg::*;
(
    input  logic [1:0] top_bits,
    input  logic       imm_bit,
    input  logic [1:0] form_bits,
    input  logic [2:0] width_code,
    output lane_w_e    lane_w,
    output logic       legal
);

    logic form_ok;

    assign form_ok = (top_bits == FORM_TOP) && !imm_bit && (form_bits == FORM_LOW);

    always_comb begin
        unique case (width_code)
            CODE_W8:  lane_w = LW_8;
            CODE_W16: lane_w = LW_16;
            CODE_W32: lane_w = LW_32;
            default:  lane_w = LW_NONE;
        endcase
    end

    assign legal = form_ok && (lane_w != LW_NONE);

    // R4: a legal decode always carries a one-hot width code
    always_comb begin
        if (legal) begin
            legal_code_onehot_chk: assert ($countones(width_code) == 1);
        end
    end

    // R3: no request outside the vector form is ever accepted
    always_comb begin
        if (legal) begin
            legal_form_chk: assert (top_bits == 2'b10 && imm_bit == 1'b0 && form_bits == 2'b10);
        end
    end

endmodule

// File: rtl/simd_addsub.sv
`timescale 1ns/1ps
module simd_addsub
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  lane_w_e           lane_w,
    output logic [DATA_W-1:0] sum
);

    localparam int NSEG = DATA_W / SEG_W;

    logic [DATA_W-1:0] b_eff;
    logic [NSEG-1:0]   lane_start;
    logic [NSEG-1:0]   cin;
    logic [NSEG-1:0]   cout;
    logic              unused_top_carry;

    assign b_eff = sub ? ~b : b;

    // a segment starts a new lane when its index is a multiple of the lane size
    always_comb begin
        int per;
        per = segs_per_lane(lane_w);
        for (int k = 0; k < NSEG; k++) begin
            lane_start[k] = ((k % per) == 0);
        end
    end

    genvar k;
    generate
        for (k = 0; k < NSEG; k++) begin : g_seg
            if (k == 0) begin : g_first
                assign cin[k] = sub;
            end else begin : g_rest
                assign cin[k] = lane_start[k] ? sub : cout[k-1];
            end
            assign {cout[k], sum[k*SEG_W +: SEG_W]} =
                {1'b0, a[k*SEG_W +: SEG_W]} + {1'b0, b_eff[k*SEG_W +: SEG_W]}
                + (SEG_W+1)'(cin[k]);
        end
    endgenerate

    assign unused_top_carry = cout[NSEG-1];

    // R6 R7: in 8-bit mode every segment takes the fresh carry-in, never a neighbour's carry
    always_comb begin
        if (lane_w == LW_8) begin
            cut_w8_chk: assert (cin == {NSEG{sub}});
        end
    end

    // R6 R7: the lowest segment always starts a lane
    always_comb begin
        lane0_start_chk: assert (lane_start[0] == 1'b1);
    end

endmodule

// File: rtl/simd_mul_bank.sv
`timescale 1ns/1ps
module simd_mul_bank #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    output logic [DATA_W-1:0] prod
);

    localparam int NLANE = DATA_W / LANE_W;

    genvar i;
    generate
        for (i = 0; i < NLANE; i++) begin : g_lane
            logic [LANE_W-1:0] x;
            logic [LANE_W-1:0] y;
            logic [LANE_W-1:0] p_u;
            logic [LANE_W-1:0] p_s;
            assign x   = a[i*LANE_W +: LANE_W];
            assign y   = b[i*LANE_W +: LANE_W];
            assign p_u = LANE_W'(x * y);
            assign p_s = LANE_W'($signed(x) * $signed(y));
            assign prod[i*LANE_W +: LANE_W] = is_signed ? p_s : p_u;
        end
    endgenerate

endmodule

// File: rtl/simd_mul.sv
`timescale 1ns/1ps
module simd_mul
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_signed,
    input  lane_w_e           lane_w,
    output logic [DATA_W-1:0] prod
);

    localparam int NWIDTH = 3;

    logic [DATA_W-1:0] bank_out [NWIDTH];

    genvar w;
    generate
        for (w = 0; w < NWIDTH; w++) begin : g_bank
            simd_mul_bank #(
                .DATA_W (DATA_W),
                .LANE_W (8 << w)
            ) u_bank (
                .a         (a),
                .b         (b),
                .is_signed (is_signed),
                .prod      (bank_out[w])
            );
        end
    endgenerate

    always_comb begin
        unique case (lane_w)
            LW_8:    prod = bank_out[0];
            LW_16:   prod = bank_out[1];
            LW_32:   prod = bank_out[2];
            default: prod = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu_unit.sv
`timescale 1ns/1ps
module simd_alu_unit
    import simd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SEG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    simd_op_e          op;
    lane_w_e           lane_w;
    logic              legal;
    logic [DATA_W-1:0] as_res;
    logic [DATA_W-1:0] mul_res;
    logic [DATA_W-1:0] nxt_result;
    logic              unused_fields;

    assign op            = simd_op_e'(op_sel);
    assign unused_fields = ^{instr[29:14], instr[12:10], instr[4:0]};

    simd_decode u_dec (
        .top_bits   (instr[31:30]),
        .imm_bit    (instr[13]),
        .form_bits  (instr[6:5]),
        .width_code (instr[9:7]),
        .lane_w     (lane_w),
        .legal      (legal)
    );

    simd_addsub #(
        .DATA_W (DATA_W),
        .SEG_W  (SEG_W)
    ) u_addsub (
        .a      (opa),
        .b      (opb),
        .sub    (op == OP_SUB),
        .lane_w (lane_w),
        .sum    (as_res)
    );

    simd_mul #(
        .DATA_W (DATA_W)
    ) u_mul (
        .a         (opa),
        .b         (opb),
        .is_signed (op == OP_SMUL),
        .lane_w    (lane_w),
        .prod      (mul_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:   nxt_result = as_res;
            OP_UMUL, OP_SMUL: nxt_result = mul_res;
            default:          nxt_result = '0;
        endcase
        if (!legal) begin
            nxt_result = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= !legal;
                out_result  <= nxt_result;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_illegal)));

    // R3 R4
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !legal) |=> (out_illegal && out_result == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_illegal && out_result == '0));

endmodule

// File: tb/simd_alu_unit_test.sv
`timescale 1ns/1ps
module simd_alu_unit_test;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [1:0]  op_sel;
    logic [63:0] opa;
    logic [63:0] opb;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int total;
    int bad;

    simd_alu_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .instr       (instr),
        .op_sel      (op_sel),
        .opa         (opa),
        .opb         (opb),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_illegal (out_illegal)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  code;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t TBL [NVEC] = '{
        '{2'b00, 3'b001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'h0000_0000_0000_0000},
        '{2'b00, 3'b010, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000},
        '{2'b00, 3'b100, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'h0000_0000_0000_0000},
        '{2'b00, 3'b001, 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 64'h8080_8080_8080_8080},
        '{2'b01, 3'b001, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'b01, 3'b100, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},
        '{2'b01, 3'b010, 64'h0000_0001_0000_0001, 64'h0001_0001_0001_0001, 64'hFFFF_0000_FFFF_0000},
        '{2'b10, 3'b001, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101},
        '{2'b10, 3'b100, 64'h0000_0002_0000_0003, 64'h0000_0005_0000_0007, 64'h0000_000A_0000_0015},
        '{2'b10, 3'b010, 64'h0100_0100_0100_0100, 64'h0100_0100_0100_0100, 64'h0000_0000_0000_0000},
        '{2'b11, 3'b010, 64'h8000_8000_8000_8000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_8000_8000_8000},
        '{2'b11, 3'b001, 64'hFEFE_FEFE_FEFE_FEFE, 64'h0303_0303_0303_0303, 64'hFAFA_FAFA_FAFA_FAFA}
    };

    function automatic logic [31:0] mk_instr(input logic [2:0] code);
        return {2'b10, 5'd2, 6'd0, 5'd4, 1'b0, 3'b000, code, 2'b10, 5'd6};
    endfunction

    function automatic logic [2:0] code_of(input int lw);
        if (lw == 8)  return 3'b001;
        if (lw == 16) return 3'b010;
        return 3'b100;
    endfunction

    // lane-by-lane reference, written from the requirements
    function automatic logic [63:0] model(input logic [1:0] op, input int lw,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] mask;
        logic [63:0] r;
        mask = (64'd1 << lw) - 64'd1;
        r = '0;
        for (int i = 0; i < 64 / lw; i++) begin
            logic [63:0] ea;
            logic [63:0] eb;
            logic [63:0] er;
            ea = (a >> (i * lw)) & mask;
            eb = (b >> (i * lw)) & mask;
            if (op == 2'b11) begin
                if (ea[lw-1]) ea = ea | ~mask;
                if (eb[lw-1]) eb = eb | ~mask;
            end
            case (op)
                2'b00:   er = ea + eb;
                2'b01:   er = ea - eb;
                default: er = ea * eb;
            endcase
            r = r | ((er & mask) << (i * lw));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one request: drive at a falling edge, sample at the next falling edge
    task automatic run_op(input logic [31:0] ins, input logic [1:0] op,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        instr    = ins;
        op_sel   = op;
        opa      = a;
        opb      = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] hold_val;
        total    = 0;
        bad      = 0;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        instr    = '0;
        op_sel   = '0;
        opa      = '0;
        opb      = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid in reset", 64'(out_valid), 64'd0);
        check("R1 result in reset", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 illegal after reset", 64'(out_illegal), 64'd0);
        check("R1 valid after reset", 64'(out_valid), 64'd0);

        // table of vectors: R5 R6 R7 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            run_op(mk_instr(TBL[i].code), TBL[i].op, TBL[i].a, TBL[i].b);
            check($sformatf("R5 R6 R7 R8 R9 table %0d", i), out_result, TBL[i].exp);
            check("R2 valid after request", 64'(out_valid), 64'd1);
        end

        // random and boundary operands at every width
        for (int i = 0; i < 360; i++) begin
            int lw;
            logic [1:0]  op;
            logic [63:0] a;
            logic [63:0] b;
            lw = 8 << (i % 3);
            op = 2'((i / 3) % 4);
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if (i % 11 == 0) a = '0;
            if (i % 13 == 0) b = '1;
            if (i % 7 == 0) begin
                for (int k = 0; k < 64 / lw; k++) a[k*lw + lw - 1 -: 1] = 1'b1;
                for (int k = 0; k < 64 / lw; k++)
                    for (int j = 0; j < lw - 1; j++) a[k*lw + j] = 1'b0;
            end
            run_op(mk_instr(code_of(lw)), op, a, b);
            case (op)
                2'b00:   check($sformatf("R6 add w%0d", lw), out_result, model(op, lw, a, b));
                2'b01:   check($sformatf("R7 sub w%0d", lw), out_result, model(op, lw, a, b));
                2'b10:   check($sformatf("R8 umul w%0d", lw), out_result, model(op, lw, a, b));
                default: check($sformatf("R9 smul w%0d", lw), out_result, model(op, lw, a, b));
            endcase
        end

        // R2: hold when idle
        run_op(mk_instr(3'b001), 2'b00, 64'h1122_3344_5566_7788, 64'h0101_0101_0101_0101);
        hold_val = out_result;
        check("R2 result before idle", hold_val, 64'h1223_3445_5667_7889);
        @(negedge clk);
        check("R2 valid low when idle", 64'(out_valid), 64'd0);
        check("R2 result held when idle", out_result, hold_val);

        // R4: illegal width codes
        foreach (TBL[i]) begin end
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2 || c == 4) continue;
            run_op(mk_instr(3'b100), 2'b00, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0101_0101_0101_0101);
            run_op(mk_instr(3'(c)), 2'b00, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0101_0101_0101_0101);
            check($sformatf("R4 flag code %0d", c), 64'(out_illegal), 64'd1);
            check($sformatf("R4 zero code %0d", c), out_result, 64'd0);
        end

        // R3: bad form bits
        for (int f = 0; f < 4; f++) begin
            logic [31:0] ins;
            ins = mk_instr(3'b001);
            case (f)
                0: ins[13]    = 1'b1;
                1: ins[6:5]   = 2'b01;
                2: ins[6:5]   = 2'b11;
                default: ins[31:30] = 2'b11;
            endcase
            run_op(mk_instr(3'b001), 2'b00, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0101_0101_0101_0101);
            run_op(ins, 2'b00, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0101_0101_0101_0101);
            check($sformatf("R3 flag form %0d", f), 64'(out_illegal), 64'd1);
            check($sformatf("R3 zero form %0d", f), out_result, 64'd0);
        end

        // R3: a legal request clears the flag again
        run_op(mk_instr(3'b010), 2'b01, 64'h0005_0005_0005_0005, 64'h0001_0001_0001_0001);
        check("R3 flag clear on legal", 64'(out_illegal), 64'd0);
        check("R3 result on legal", out_result, 64'h0004_0004_0004_0004);

        // R10: other instruction fields do not matter
        for (int i = 0; i < 20; i++) begin
            logic [31:0] ins;
            logic [63:0] a;
            logic [63:0] b;
            ins = $urandom;
            ins[31:30] = 2'b10;
            ins[13]    = 1'b0;
            ins[9:7]   = 3'b001;
            ins[6:5]   = 2'b10;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            run_op(ins, 2'b11, a, b);
            check("R10 field independence result", out_result, model(2'b11, 8, a, b));
            check("R10 field independence flag", 64'(out_illegal), 64'd0);
        end

        // R1: reset in the middle of activity
        run_op(mk_instr(3'b001), 2'b00, 64'h1111_1111_1111_1111, 64'h1111_1111_1111_1111);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 result cleared by reset", out_result, 64'd0);
        check("R1 valid cleared by reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule